// File: doc/BRIEF.md
# IO Bus Address Translation Unit

This block maps device bus addresses that fall inside a fixed window at the top of the 32-bit bus space onto physical memory addresses. A flat page table in memory holds one 32-bit entry for each 4 KB page of the window. The entry's index is the page number of the bus address counted from the window start. A small fully associative translation cache holds recent entries, so most accesses need no table read. On a miss the block raises a read on its memory port, waits for the entry and stalls the requester until then. It decodes the entry, checks permissions, and either returns the physical address or reports a fault and captures the bus address that caused it.

Software controls the block through four word registers. The control register turns translation on and selects the window size, and it also returns fixed implementation and version numbers. The table base register takes the table's physical address shifted right by 4. Two write-only command registers flush either the whole cache or only the page that holds a written bus address. When translation is off, or an address lies below the window, the request passes through unchanged.

Top module: `iova_xlate`

## Requirements
- R1: After reset, translation is off, no response or table read is pending, `req_ready` is 1, and every cache entry is empty.
- R2: Register 0 reads back the implementation number in bits 31:28 and the version in bits 27:24. It also reads back the writable range code in bits 4:2 and the enable bit in bit 0. Range code r gives a window of (16 MB << r) that ends at 0xFFFFFFFF, so code 4 places the 256 MB window at 0xF0000000. Register 1 holds the table base.
- R3: When translation is disabled, or the request address is below the window start, the response follows one cycle after acceptance. It carries `{4'b0, req_addr}` with no fault, is marked not cacheable, and issues no table read.
- R4: On a miss, the table read starts in the cycle after acceptance and holds until `mem_rd_ack`. Its address is (base << 4) + 4 × ((bus address − window start) >> 12). `req_ready` stays low for the whole fetch.
- R5: In an entry, bit 1 is valid, bit 2 is writable, bit 7 is cacheable and bits 31:8 are the page field. The physical address is {page field, bus address[11:0]}, 36 bits wide. The response follows one cycle after `mem_rd_ack`.
- R6: An entry with bit 1 clear, including an all-zero entry, gives a fault. The fault response has `resp_addr` = 0 and is not cacheable. It loads the bus address into `fault_addr`, and the entry is not cached, so a repeat access reads the table again.
- R7: A write through an entry without the writable bit faults, whether the entry came from a hit or a fetch. A read through the same entry translates normally, and a valid write-protected entry is still cached.
- R8: A request that hits a cached entry responds one cycle after acceptance, with no table read.
- R9: The cache holds 16 entries filled in round-robin order. After 17 distinct pages are installed, the first of them is gone and the last 16 still hit.
- R10: Any write to register 2 empties the whole cache.
- R11: A write of a bus address to register 3 drops only the cached entry for that page. Other pages still hit.
- R12: An invalidate written while a table read is outstanding lets the fetched entry produce its response but stops it from being cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 base, 2 flush all, 3 flush page |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Device bus address |
| req_write | input | 1 | Request is a device write |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_addr | output | 36 | Physical address, zero on fault |
| resp_cacheable | output | 1 | Entry's cacheable flag |
| resp_fault | output | 1 | Translation fault |
| fault_addr | output | 32 | Bus address of the last fault |
| mem_rd_valid | output | 1 | Table read request, held until acknowledged |
| mem_rd_addr | output | 32 | Physical address of the table entry |
| mem_rd_ack | input | 1 | Table read data is valid this cycle |
| mem_rd_data | input | 32 | Table entry |

## Verification
The assertions assume that memory holds `mem_rd_valid` only until it returns one `mem_rd_ack`, and that it never acknowledges a read that was not requested. They also assume the block never sees a register write and a request acceptance in the same cycle. The bench's memory responder acknowledges every read exactly two cycles after it appears and stays idle otherwise. Stimulus issues register writes only between transactions. The one exception is the deliberate invalidate during an outstanding fetch, and it lands while `req_ready` is low.

// File: rtl/iova_xlate.sv
module iova_xlate #(
  parameter int          TLB_N   = 16,
  parameter logic [3:0]  IMPL_ID = 4'h3,
  parameter logic [3:0]  VER_ID  = 4'h1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  output logic        resp_valid,
  output logic [35:0] resp_addr,
  output logic        resp_cacheable,
  output logic        resp_fault,
  output logic [31:0] fault_addr,
  output logic        mem_rd_valid,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_ack,
  input  logic [31:0] mem_rd_data
);
  localparam int PW = $clog2(TLB_N);

  logic        en;
  logic [2:0]  range;
  logic [31:0] base;
  logic        busy, p_write, p_kill;
  logic [31:0] p_addr;

  logic [TLB_N-1:0] t_v, t_w, t_c;
  logic [19:0]      t_tag [TLB_N];
  logic [23:0]      t_ppn [TLB_N];
  logic [PW-1:0]    rr;

  logic [19:0] win_pg, off_pg;
  logic [31:0] pte_addr;
  logic        translate, accept, inv_all, inv_pg, hit, install, do_resp;
  logic [PW-1:0] hit_idx;

  assign win_pg    = ~((20'h01000 << range) - 20'h1);
  assign off_pg    = req_addr[31:12] - win_pg;
  assign pte_addr  = {base[27:0], 4'b0} + {10'b0, off_pg, 2'b0};
  assign translate = en && (req_addr[31:12] >= win_pg);
  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign inv_all   = reg_wr && reg_addr == 2'd2;
  assign inv_pg    = reg_wr && reg_addr == 2'd3;

  always_comb begin
    unique case (reg_addr)
      2'd0:    reg_rdata = {IMPL_ID, VER_ID, 19'b0, range, 1'b0, en};
      2'd1:    reg_rdata = base;
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < TLB_N; i++)
      if (t_v[i] && t_tag[i] == req_addr[31:12]) begin
        hit = 1'b1;
        hit_idx = PW'(i);
      end
  end

  // entry being answered: fetched PTE when busy, cached entry otherwise
  logic        e_v, e_w, e_c, r_wr, e_fault;
  logic [23:0] e_ppn;
  logic [31:0] r_addr;
  assign r_addr  = busy ? p_addr  : req_addr;
  assign r_wr    = busy ? p_write : req_write;
  assign e_v     = busy ? mem_rd_data[1] : 1'b1;
  assign e_w     = busy ? mem_rd_data[2] : t_w[hit_idx];
  assign e_c     = busy ? mem_rd_data[7] : t_c[hit_idx];
  assign e_ppn   = busy ? mem_rd_data[31:8] : t_ppn[hit_idx];
  assign e_fault = !e_v || (r_wr && !e_w);
  assign do_resp = (accept && translate && hit) || (busy && mem_rd_ack);
  assign install = busy && mem_rd_ack && mem_rd_data[1] && !p_kill && !inv_all && !inv_pg;

  wire unused_bits = &{1'b0, mem_rd_data[6:3], mem_rd_data[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0;
      range <= '0;
      base <= '0;
    end else if (reg_wr) begin
      if (reg_addr == 2'd0) begin
        en <= reg_wdata[0];
        range <= reg_wdata[4:2];
      end
      if (reg_addr == 2'd1) base <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_v <= '0;
      rr <= '0;
    end else begin
      for (int i = 0; i < TLB_N; i++)
        if (inv_all || (inv_pg && t_tag[i] == reg_wdata[31:12])) t_v[i] <= 1'b0;
      if (install) begin
        t_v[rr]   <= 1'b1;
        t_w[rr]   <= mem_rd_data[2];
        t_c[rr]   <= mem_rd_data[7];
        t_tag[rr] <= p_addr[31:12];
        t_ppn[rr] <= mem_rd_data[31:8];
        rr <= (rr == PW'(TLB_N - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      p_kill <= 1'b0;
      p_write <= 1'b0;
      p_addr <= '0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr <= '0;
      resp_valid <= 1'b0;
      resp_addr <= '0;
      resp_cacheable <= 1'b0;
      resp_fault <= 1'b0;
      fault_addr <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (accept && !translate) begin
        resp_valid <= 1'b1;
        resp_addr <= {4'b0, req_addr};
        resp_cacheable <= 1'b0;
        resp_fault <= 1'b0;
      end else if (accept && !hit) begin
        busy <= 1'b1;
        mem_rd_valid <= 1'b1;
        mem_rd_addr <= pte_addr;
        p_addr <= req_addr;
        p_write <= req_write;
        p_kill <= 1'b0;
      end
      if (busy && (inv_all || inv_pg)) p_kill <= 1'b1;
      if (busy && mem_rd_ack) begin
        busy <= 1'b0;
        mem_rd_valid <= 1'b0;
      end
      if (do_resp) begin
        resp_valid <= 1'b1;
        resp_fault <= e_fault;
        resp_addr <= e_fault ? 36'b0 : {e_ppn, r_addr[11:0]};
        resp_cacheable <= !e_fault && e_c;
        if (e_fault) fault_addr <= r_addr;
      end
    end
  end
endmodule

// File: rtl/iova_xlate_chk.sv
module iova_xlate_chk #(
  parameter logic [3:0] IMPL_ID = 4'h3,
  parameter logic [3:0] VER_ID  = 4'h1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic        req_ready,
  input logic        resp_valid,
  input logic [35:0] resp_addr,
  input logic        resp_cacheable,
  input logic        resp_fault,
  input logic        mem_rd_valid,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_ack
);
  AST_FETCH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready); // R4
  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ack |=> mem_rd_valid && $stable(mem_rd_addr)); // R4
  AST_ACK_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && mem_rd_ack |=> resp_valid && !mem_rd_valid); // R5
  AST_FAULT_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_addr == 36'b0 && !resp_cacheable); // R6
  AST_ID_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd0 |-> reg_rdata[31:24] == {IMPL_ID, VER_ID}); // R2
  AST_READY_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready); // R8
endmodule

bind iova_xlate iova_xlate_chk #(.IMPL_ID(IMPL_ID), .VER_ID(VER_ID)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .req_ready(req_ready), .resp_valid(resp_valid), .resp_addr(resp_addr),
  .resp_cacheable(resp_cacheable), .resp_fault(resp_fault),
  .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack)
);

// File: tb/iova_xlate_tb_top.sv
module iova_xlate_tb_top;
  localparam logic [3:0] IMPL = 4'h3, VER = 4'h1;
  localparam logic [31:0] TBL = 32'h0040_0000;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [1:0] reg_addr = 0; logic [31:0] reg_wdata = 0; logic [31:0] reg_rdata;
  logic req_valid = 0, req_ready, req_write = 0; logic [31:0] req_addr = 0;
  logic resp_valid, resp_cacheable, resp_fault; logic [35:0] resp_addr; logic [31:0] fault_addr;
  logic mem_rd_valid; logic [31:0] mem_rd_addr; logic mem_rd_ack = 0; logic [31:0] mem_rd_data = 0;

  iova_xlate #(.TLB_N(16), .IMPL_ID(IMPL), .VER_ID(VER)) dut_i (.*);

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, n_fetch = 0;
  logic [31:0] last_fetch;
  bit in_wait = 0, done = 0;
  logic [31:0] ptes [int unsigned];

  // reference state
  bit m_en = 0; int m_range = 0; logic [31:0] m_base = 0, m_faddr = 0;
  bit m_tv [16]; logic [19:0] m_tag [16]; logic [23:0] m_ppn [16]; bit m_w [16], m_c [16];
  int m_ptr = 0;

  task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [31:0] wstart(int r);
    return ~((32'h0100_0000 << r) - 32'h1);
  endfunction

  // memory responder: acknowledges two cycles after a read appears
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_rd_ack) begin mem_rd_ack = 0; cnt = 0; end
      else if (mem_rd_valid) begin
        cnt++;
        if (cnt == 2) begin
          mem_rd_ack = 1;
          mem_rd_data = ptes.exists(mem_rd_addr) ? ptes[mem_rd_addr] : 32'h0;
          n_fetch++; last_fetch = mem_rd_addr;
        end
      end else cnt = 0;
    end
  end

  // per-clock comparison: no response outside an awaited transaction (R3, R8)
  always @(negedge clk) if (rst_n && !done) begin
    n_cmp++;
    if (resp_valid && !in_wait) begin
      n_bad++;
      $display("FAIL R3 stray response: actual 1 expected 0");
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic m_inval(bit all, logic [31:0] a);
    for (int i = 0; i < 16; i++) if (all || m_tag[i] == a[31:12]) m_tv[i] = 0;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_addr = 0;
    if (a == 0) begin m_en = d[0]; m_range = int'(d[4:2]); end
    if (a == 1) m_base = d;
    if (a == 2) m_inval(1, d);
    if (a == 3) m_inval(0, d);
  endtask

  // inv: 0 none, 1 flush all, 2 flush page of a, issued during the fetch
  task automatic xlate(string r, logic [31:0] a, bit wr, int inv = 0);
    bit fetch = 0, fault = 0, c = 0, hit = 0, did = 0;
    logic [35:0] pa; logic [31:0] paddr = 0, pte; int lat = 0, f0;
    logic [31:0] ws = wstart(m_range);
    if (!m_en || a < ws) pa = {4'b0, a};
    else begin
      for (int i = 0; i < 16; i++)
        if (m_tv[i] && m_tag[i] == a[31:12]) begin
          hit = 1; c = m_c[i]; fault = wr && !m_w[i];
          pa = {m_ppn[i], a[11:0]};
        end
      if (!hit) begin
        fetch = 1;
        paddr = m_base * 16 + ((a - ws) >> 12) * 4;
        pte = ptes.exists(paddr) ? ptes[paddr] : 32'h0;
        fault = !pte[1] || (wr && !pte[2]);
        c = pte[7]; pa = {pte[31:8], a[11:0]};
        if (pte[1] && inv == 0) begin
          m_tv[m_ptr] = 1; m_tag[m_ptr] = a[31:12]; m_ppn[m_ptr] = pte[31:8];
          m_w[m_ptr] = pte[2]; m_c[m_ptr] = pte[7]; m_ptr = (m_ptr + 1) % 16;
        end
      end
      if (fault) begin pa = 0; c = 0; m_faddr = a; end
    end
    if (inv != 0) m_inval(inv == 1, a);
    f0 = n_fetch;
    @(negedge clk); req_valid = 1; req_addr = a; req_write = wr; in_wait = 1;
    @(posedge clk);
    while (lat < 20) begin
      @(negedge clk); lat++;
      if (lat == 1) req_valid = 0;
      if (reg_wr) reg_wr = 0;
      if (inv != 0 && !did && mem_rd_valid) begin
        reg_wr = 1; reg_addr = (inv == 1) ? 2'd2 : 2'd3; reg_wdata = a; did = 1;
      end
      if (resp_valid) break;
    end
    chk(r, "latency", 64'(lat), fetch ? 64'd3 : 64'd1);
    chk(r, "resp_addr", 64'(resp_addr), 64'(pa));
    chk(r, "resp_fault", 64'(resp_fault), 64'(fault));
    chk(r, "resp_cacheable", 64'(resp_cacheable), 64'(c));
    chk(r, "fault_addr", 64'(fault_addr), 64'(m_faddr));
    chk(r, "table reads", 64'(n_fetch - f0), fetch ? 64'd1 : 64'd0);
    if (fetch) chk("R4", "table read address", 64'(last_fetch), 64'(paddr));
    @(negedge clk); in_wait = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "resp_valid", 64'(resp_valid), 0);
    chk("R1", "mem_rd_valid", 64'(mem_rd_valid), 0);
    chk("R1", "req_ready", 64'(req_ready), 1);
    rst_n = 1;
    @(negedge clk); reg_addr = 0; #1;
    chk("R1", "control after reset", 64'(reg_rdata), 64'({IMPL, VER, 24'h0}));

    ptes[TBL + 0] = 32'h000A_BC86;   // valid, writable, cacheable
    ptes[TBL + 4] = 32'h00DE_F002;   // valid, read-only
    ptes[TBL + 8] = 32'h0000_0000;   // unmapped
    for (int i = 16; i <= 40; i++) ptes[TBL + i * 4] = ((32'h100 + i) << 8) | 32'h6;

    wr_reg(1, TBL >> 4);
    wr_reg(0, 32'h10);                        // range 4, disabled
    xlate("R3", 32'hF000_1234, 1);            // disabled: pass through
    wr_reg(0, 32'h11);
    @(negedge clk); reg_addr = 0; #1;
    chk("R2", "control readback", 64'(reg_rdata), 64'({IMPL, VER, 24'h11}));
    reg_addr = 1; #1;
    chk("R2", "base readback", 64'(reg_rdata), 64'(TBL >> 4));
    xlate("R3", 32'h1234_5678, 0);            // below window

    xlate("R5", 32'hF000_0123, 0);            // miss, cacheable
    xlate("R8", 32'hF000_0FFC, 0);            // hit
    xlate("R8", 32'hF000_0010, 1);            // hit write
    xlate("R7", 32'hF000_1010, 1);            // miss, write-protect fault
    xlate("R7", 32'hF000_1020, 0);            // hit read ok
    xlate("R7", 32'hF000_1030, 1);            // hit write fault
    xlate("R6", 32'hF000_2000, 0);            // unmapped
    xlate("R6", 32'hF000_2004, 0);            // fetched again

    wr_reg(3, 32'hF000_0ABC);
    xlate("R11", 32'hF000_0100, 0);           // dropped page refetched
    xlate("R11", 32'hF000_1100, 0);           // other page still hits
    wr_reg(2, 32'h0);
    xlate("R10", 32'hF000_1100, 0);
    xlate("R10", 32'hF000_0100, 0);

    wr_reg(2, 32'h0);
    for (int i = 16; i <= 32; i++) xlate("R9", 32'hF000_0000 + (i << 12), 0);
    xlate("R9", 32'hF001_0000, 0);            // first installed, evicted
    xlate("R9", 32'hF002_0008, 0);            // recent, hits

    xlate("R12", 32'hF002_8000, 0, 1);        // flush-all during fetch
    xlate("R12", 32'hF002_8004, 0);           // not cached
    xlate("R12", 32'hF002_7000, 0, 2);        // page flush during fetch
    xlate("R12", 32'hF002_7004, 0);

    wr_reg(2, 32'h0);
    wr_reg(0, 32'h0D);                        // range 3: 128 MB window
    xlate("R2", 32'hF400_0000, 0);            // now below window
    xlate("R2", 32'hF800_0040, 0);            // index 0

    done = 1;
    finish_run();
  end
endmodule